// File: doc/BRIEF.md
# Event Timer Global Register Block

This block holds the shared registers of a multi-channel event timer: a fixed capabilities word, a 64-bit configuration word whose bit 0 starts and stops counting, and a 32-bit main counter. Software reaches them over a simple memory-mapped bus. Each request lasts one cycle and carries a byte offset, a size of 4 or 8 bytes and 64 bits of write data. Read data comes back one cycle later. A 4-byte access reaches one half of a 64-bit register. A write merges only the bytes it covers, and a read returns only the half it names.

The counter advances by one on each cycle in which `tick_en` is high while counting is enabled, so an external prescaler sets the tick rate. The per-channel comparator blocks take `count_value` and `count_enable` from this block. They use the one-cycle `enable_rise` pulse to re-arm when counting starts.

Counting is controlled by a three-state machine. HALTED is the reset state. A configuration write that sets bit 0 moves it from HALTED to ARMING. ARMING lasts one cycle and drives `enable_rise`. From ARMING it moves to RUNNING, or back to HALTED if the same-cycle write clears bit 0. RUNNING returns to HALTED when a configuration write clears bit 0. Counting takes place in ARMING and in RUNNING.

Top module: `evt_global_regs`

## Requirements
- R1: After reset the counter, the configuration word, `count_enable`, `enable_rise` and `bus_rvalid` are all zero.
- R2: The capabilities word at offset 0x000 reads 0x05F5E100_80860701. Bits 63:32 hold the tick period in femtoseconds (100000000). Bits 31:16 hold vendor code 0x8086, bit 13 is 0 (32-bit counter) and bits 12:8 hold timers minus one (7). Bits 7:0 hold revision 1. Writes to it have no effect.
- R3: A request with a size other than 4 or 8 leaves every register unchanged on write and returns zero on read.
- R4: A request whose offset is not a multiple of its size is rejected: a write changes nothing and a read returns zero.
- R5: A 4-byte request with offset bit 2 set targets bits 63:32 of the register: a write updates only those bits, and a read returns them in bits 31:0. A 4-byte request with bit 2 clear targets bits 31:0, and its read returns them zero-extended.
- R6: While enabled, the counter rises by exactly one in each cycle with `tick_en` high and wraps from 0xFFFFFFFF to 0. With `tick_en` low it holds.
- R7: Clearing configuration bit 0 (offset 0x010) freezes the counter at its present value. Setting the bit again resumes counting from that value. `count_enable` always equals the stored bit 0.
- R8: Configuration bit 1 (legacy routing) always reads zero. The other configuration bits read back what was written.
- R9: A write to the counter (offset 0x0F0) zero-extends the present count, merges the written bytes and keeps the low 32 bits. A 4-byte write at 0x0F4 therefore leaves the count unchanged. A counter write takes precedence over a tick in the same cycle.
- R10: Reads from offsets outside the three registers return zero, and writes to them change nothing.
- R11: `enable_rise` is high for exactly one cycle, the first cycle in which `count_enable` is high after a write takes bit 0 from 0 to 1.
- R12: A read raises `bus_rvalid` in the next cycle with the data. A counter read returns the value held in the cycle of the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Request present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_offset | input | 12 | Byte offset of the request |
| bus_size | input | 4 | Access size in bytes |
| bus_wdata | input | 64 | Write data, low-aligned for 4-byte requests |
| bus_rvalid | output | 1 | Read response valid |
| bus_rdata | output | 64 | Read response data, zero when not a read response |
| tick_en | input | 1 | Counter advance qualifier |
| count_value | output | 32 | Main counter value |
| count_enable | output | 1 | Counting enabled level |
| enable_rise | output | 1 | One-cycle pulse when counting is switched on |

## Verification
The properties assume that a request is a single-cycle strobe with offset, size and data valid alongside it. They also assume that `tick_en` may take any pattern, including high in the same cycle as a counter write. For that case the counter-step properties exclude cycles with a counter write. The stimulus drives every request for exactly one cycle between falling edges. It mixes tick patterns (every cycle, every third cycle, none) and deliberately places counter writes, enable toggles and rejected requests while ticks continue. This way both the merge precedence and the freeze behaviour are tested under live counting.

// File: rtl/evt_pkg.sv
package evt_pkg;

    localparam int CNT_W  = 32;
    localparam int DATA_W = 64;
    localparam int HALF_W = DATA_W / 2;

    // Register selected by an access
    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_CAP  = 2'd1,
        TGT_CFG  = 2'd2,
        TGT_CNT  = 2'd3
    } evt_tgt_e;

    // Counting control state
    typedef enum logic [1:0] {
        CS_HALTED  = 2'd0,
        CS_ARMING  = 2'd1,
        CS_RUNNING = 2'd2
    } evt_cstate_e;

endpackage

// File: rtl/evt_access_decode.sv
module evt_access_decode
    import evt_pkg::*;
#(
    parameter int                ADDR_W  = 12,
    parameter logic [ADDR_W-1:0] OFS_CAP = 12'h000,
    parameter logic [ADDR_W-1:0] OFS_CFG = 12'h010,
    parameter logic [ADDR_W-1:0] OFS_CNT = 12'h0F0
) (
    input  logic [ADDR_W-1:0] acc_offset,
    input  logic [3:0]        acc_size,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic              dec_ok,
    output logic              dec_hi,
    output logic              dec_wide,
    output evt_tgt_e          dec_tgt,
    output logic [DATA_W-1:0] lane_mask,
    output logic [DATA_W-1:0] lane_data
);

    logic              size_ok;
    logic              align_ok;
    logic [ADDR_W-1:0] word_base;

    always_comb begin
        dec_wide  = (acc_size == 4'd8);
        size_ok   = dec_wide || (acc_size == 4'd4);
        align_ok  = dec_wide ? (acc_offset[2:0] == 3'b000)
                             : (acc_offset[1:0] == 2'b00);
        dec_ok    = size_ok && align_ok;
        dec_hi    = !dec_wide && acc_offset[2];
        word_base = {acc_offset[ADDR_W-1:3], 3'b000};
    end

    always_comb begin
        if (word_base == OFS_CAP)      dec_tgt = TGT_CAP;
        else if (word_base == OFS_CFG) dec_tgt = TGT_CFG;
        else if (word_base == OFS_CNT) dec_tgt = TGT_CNT;
        else                           dec_tgt = TGT_NONE;
    end

    // Byte-lane placement of write data
    always_comb begin
        if (dec_wide) begin
            lane_mask = '1;
            lane_data = acc_wdata;
        end else if (dec_hi) begin
            lane_mask = {{HALF_W{1'b1}}, {HALF_W{1'b0}}};
            lane_data = {acc_wdata[HALF_W-1:0], {HALF_W{1'b0}}};
        end else begin
            lane_mask = {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
            lane_data = {{HALF_W{1'b0}}, acc_wdata[HALF_W-1:0]};
        end
    end

endmodule

// File: rtl/evt_gcounter.sv
module evt_gcounter
    import evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_wr,
    input  logic             en_val,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             tick_en,
    output logic [CNT_W-1:0] cnt_q,
    output logic             run_o,
    output logic             rise_o
);

    evt_cstate_e state_q;
    evt_cstate_e state_d;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_HALTED:  if (en_wr && en_val) state_d = CS_ARMING;
            CS_ARMING:  state_d = (en_wr && !en_val) ? CS_HALTED : CS_RUNNING;
            CS_RUNNING: if (en_wr && !en_val) state_d = CS_HALTED;
            default:    state_d = CS_HALTED;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CS_HALTED;
        else        state_q <= state_d;
    end

    // Outputs from state
    always_comb begin
        run_o  = 1'b0;
        rise_o = 1'b0;
        unique case (state_q)
            CS_HALTED:  ;
            CS_ARMING:  begin run_o = 1'b1; rise_o = 1'b1; end
            CS_RUNNING: run_o = 1'b1;
            default:    ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (cnt_wr)            cnt_q <= cnt_wdata;
        else if (run_o && tick_en)  cnt_q <= cnt_q + 1'b1;
    end

    p_tick_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && tick_en && !cnt_wr) |=> (cnt_q == $past(cnt_q) + 1'b1));

    p_halt_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_o && !cnt_wr) |=> $stable(cnt_q));

    p_pulse_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

    p_pulse_from_halt_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_o && en_wr && en_val) |=> rise_o);

endmodule

// File: rtl/evt_global_regs.sv
module evt_global_regs
    import evt_pkg::*;
#(
    parameter int                ADDR_W     = 12,
    parameter int                NUM_TIMERS = 8,
    parameter int unsigned       TICK_FS    = 100000000,
    parameter logic [15:0]       VENDOR_ID  = 16'h8086,
    parameter logic [7:0]        REVISION   = 8'h01,
    parameter logic [ADDR_W-1:0] OFS_CAP    = 12'h000,
    parameter logic [ADDR_W-1:0] OFS_CFG    = 12'h010,
    parameter logic [ADDR_W-1:0] OFS_CNT    = 12'h0F0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_offset,
    input  logic [3:0]        bus_size,
    input  logic [63:0]       bus_wdata,
    output logic              bus_rvalid,
    output logic [63:0]       bus_rdata,
    input  logic              tick_en,
    output logic [31:0]       count_value,
    output logic              count_enable,
    output logic              enable_rise
);

    localparam int CFG_EN_BIT  = 0;
    localparam int CFG_LEG_BIT = 1;
    // bits 15:13 = legacy capable, reserved, 64-bit counter: all zero
    localparam logic [DATA_W-1:0] CAP_WORD =
        {32'(TICK_FS), VENDOR_ID, 3'b000, 5'(NUM_TIMERS - 1), REVISION};

    logic              dec_ok;
    logic              dec_hi;
    logic              dec_wide;
    evt_tgt_e          dec_tgt;
    logic [DATA_W-1:0] lane_mask;
    logic [DATA_W-1:0] lane_data;

    evt_access_decode #(
        .ADDR_W  (ADDR_W),
        .OFS_CAP (OFS_CAP),
        .OFS_CFG (OFS_CFG),
        .OFS_CNT (OFS_CNT)
    ) u_decode (
        .acc_offset (bus_offset),
        .acc_size   (bus_size),
        .acc_wdata  (bus_wdata),
        .dec_ok     (dec_ok),
        .dec_hi     (dec_hi),
        .dec_wide   (dec_wide),
        .dec_tgt    (dec_tgt),
        .lane_mask  (lane_mask),
        .lane_data  (lane_data)
    );

    logic              wr_ok;
    logic              rd_req;
    logic [DATA_W-1:0] cfg_q;
    logic [DATA_W-1:0] cfg_d;
    logic              cfg_wr;
    logic              cnt_wr;
    logic [CNT_W-1:0]  cnt_merge;
    logic [CNT_W-1:0]  cnt_q;
    logic              run;
    logic              rise;

    always_comb begin
        wr_ok  = bus_valid && bus_write && dec_ok;
        rd_req = bus_valid && !bus_write;
        cfg_wr = wr_ok && (dec_tgt == TGT_CFG);
        cnt_wr = wr_ok && (dec_tgt == TGT_CNT);
        cfg_d  = (cfg_q & ~lane_mask) | (lane_data & lane_mask);
        cfg_d[CFG_LEG_BIT] = 1'b0;
        cnt_merge = (cnt_q & ~lane_mask[CNT_W-1:0])
                  | (lane_data[CNT_W-1:0] & lane_mask[CNT_W-1:0]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_wr) cfg_q <= cfg_d;
    end

    evt_gcounter u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_wr     (cfg_wr),
        .en_val    (cfg_d[CFG_EN_BIT]),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (cnt_merge),
        .tick_en   (tick_en),
        .cnt_q     (cnt_q),
        .run_o     (run),
        .rise_o    (rise)
    );

    // Read path
    logic [DATA_W-1:0] rd_sel;
    logic [DATA_W-1:0] rd_word;

    always_comb begin
        unique case (dec_tgt)
            TGT_CAP:  rd_sel = CAP_WORD;
            TGT_CFG:  rd_sel = cfg_q;
            TGT_CNT:  rd_sel = {{(DATA_W-CNT_W){1'b0}}, cnt_q};
            default:  rd_sel = '0;
        endcase
        if (!dec_ok)       rd_word = '0;
        else if (dec_wide) rd_word = rd_sel;
        else if (dec_hi)   rd_word = {{HALF_W{1'b0}}, rd_sel[DATA_W-1:HALF_W]};
        else               rd_word = {{HALF_W{1'b0}}, rd_sel[HALF_W-1:0]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= rd_req;
            bus_rdata  <= rd_req ? rd_word : '0;
        end
    end

    assign count_value  = cnt_q;
    assign count_enable = run;
    assign enable_rise  = rise;

    p_bad_size_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_size != 4'd4 && bus_size != 4'd8)
        |=> $stable(cfg_q));

    p_bad_size_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_size != 4'd4 && bus_size != 4'd8)
        |=> (bus_rvalid && bus_rdata == '0));

    p_misaligned_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_size == 4'd8 && bus_offset[2:0] != 3'b000)
        |=> $stable(cfg_q));

    p_enable_tracks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        count_enable == cfg_q[CFG_EN_BIT]);

    p_resp_next_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write) |=> bus_rvalid);

    p_no_spurious_resp_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_write) |=> !bus_rvalid);

endmodule

// File: tb/evt_global_regs_tb_top.sv
module evt_global_regs_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;
    localparam logic [63:0] CAP_EXP = 64'h05F5E100_80860701;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [11:0] bus_offset = '0;
    logic [3:0]  bus_size = '0;
    logic [63:0] bus_wdata = '0;
    logic        bus_rvalid;
    logic [63:0] bus_rdata;
    logic        tick_en = 1'b0;
    logic [31:0] count_value;
    logic        count_enable;
    logic        enable_rise;

    int    vectors = 0;
    int    fails = 0;
    int    cyc = 0;
    int    tick_div = 0;
    bit    done = 0;
    string tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_global_regs dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_valid    (bus_valid),
        .bus_write    (bus_write),
        .bus_offset   (bus_offset),
        .bus_size     (bus_size),
        .bus_wdata    (bus_wdata),
        .bus_rvalid   (bus_rvalid),
        .bus_rdata    (bus_rdata),
        .tick_en      (tick_en),
        .count_value  (count_value),
        .count_enable (count_enable),
        .enable_rise  (enable_rise)
    );

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_cnt;
    logic [63:0] m_cfg;
    bit          m_rise, m_rv;
    logic [63:0] m_rd;

    always @(posedge clk) begin
        bit          good, lo_w, hi_w;
        int          off, base;
        logic [63:0] reg_v, rd_v, nc;
        logic [31:0] nn;
        bit          nr;
        if (!rst_n) begin
            m_cnt = 0; m_cfg = 0; m_rise = 0; m_rv = 0; m_rd = 0;
        end else begin
            off  = int'(bus_offset);
            good = (bus_size == 4 && off % 4 == 0) || (bus_size == 8 && off % 8 == 0);
            base = off - off % 8;
            if (base == 0)        reg_v = CAP_EXP;
            else if (base == 16)  reg_v = m_cfg;
            else if (base == 240) reg_v = {32'd0, m_cnt};
            else                  reg_v = 0;
            if (bus_size == 8)    rd_v = reg_v;
            else if (off % 8 == 4) rd_v = reg_v >> 32;
            else                  rd_v = reg_v & 64'hFFFF_FFFF;
            nc = m_cfg;
            nr = 0;
            nn = (m_cfg[0] && tick_en) ? m_cnt + 1 : m_cnt;
            if (bus_valid && bus_write && good) begin
                lo_w = (bus_size == 8) || (off % 8 == 0);
                hi_w = (bus_size == 8) || (off % 8 == 4);
                if (base == 16) begin
                    if (lo_w) nc[31:0] = bus_wdata[31:0];
                    if (hi_w) nc[63:32] = (bus_size == 8) ? bus_wdata[63:32] : bus_wdata[31:0];
                    nc[1] = 0;
                    nr = !m_cfg[0] && nc[0];
                end else if (base == 240) begin
                    nn = lo_w ? bus_wdata[31:0] : m_cnt;
                end
            end
            m_rv   = bus_valid && !bus_write;
            m_rd   = (m_rv && good) ? rd_v : 64'd0;
            m_cnt  = nn;
            m_cfg  = nc;
            m_rise = nr;
        end
    end

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string what);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        cyc++;
        tick_en = (tick_div != 0) && (cyc % tick_div == 0);
        if (rst_n && !done) begin
            chk(64'(count_value), 64'(m_cnt), "count_value");
            chk(64'(count_enable), 64'(m_cfg[0]), "count_enable");
            chk(64'(enable_rise), 64'(m_rise), "enable_rise");
            chk(64'(bus_rvalid), 64'(m_rv), "bus_rvalid");
            chk(bus_rdata, m_rd, "bus_rdata");
        end
    end

    task automatic req(input bit wr, input int off, input int sz, input logic [63:0] d);
        @(negedge clk);
        bus_valid = 1; bus_write = wr; bus_offset = 12'(off); bus_size = 4'(sz); bus_wdata = d;
        @(negedge clk);
        bus_valid = 0; bus_write = 0;
    endtask

    task automatic rd_chk(input int off, input int sz, input logic [63:0] exp, input string what);
        req(0, off, sz, 64'd0);
        chk(bus_rdata, exp, what);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        idle(3);
        rst_n = 1;
        @(negedge clk);
        tag = "R1";
        chk(64'(count_value), 0, "reset count");
        chk(64'(count_enable), 0, "reset enable");
        rd_chk(16, 8, 0, "reset cfg");

        tag = "R2";
        rd_chk(0, 8, CAP_EXP, "cap 8B");
        rd_chk(0, 4, 64'h80860701, "cap low");
        rd_chk(4, 4, 64'h05F5E100, "cap high");
        req(1, 0, 8, 64'd0);
        rd_chk(0, 8, CAP_EXP, "cap after write");

        tag = "R3";
        req(1, 16, 2, 64'h1);
        rd_chk(16, 8, 0, "cfg after size-2 write");
        rd_chk(0, 1, 0, "size-1 read");
        rd_chk(0, 2, 0, "size-2 read");

        tag = "R4";
        req(1, 20, 8, 64'h1);
        req(1, 18, 4, 64'h1);
        rd_chk(16, 8, 0, "cfg after misaligned writes");
        rd_chk(4, 8, 0, "misaligned cap read");

        tag = "R5";
        req(1, 20, 4, 64'h0000_0000_A5A5_0000);
        rd_chk(16, 8, 64'hA5A50000_00000000, "upper-half write");
        rd_chk(16, 4, 0, "low half read");
        rd_chk(20, 4, 64'hA5A50000, "high half read");

        tag = "R8";
        tick_div = 0;
        req(1, 16, 8, 64'hFFFF_FFFF_FFFF_FFFF);
        rd_chk(16, 8, 64'hFFFF_FFFF_FFFF_FFFD, "legacy bit zero");
        req(1, 16, 8, 64'd0);
        rd_chk(16, 8, 0, "cfg cleared");

        tag = "R11";
        tick_div = 1;
        req(1, 16, 4, 64'h1);
        chk(64'(enable_rise), 1, "pulse after enable");
        @(negedge clk);
        chk(64'(enable_rise), 0, "pulse gone");

        tag = "R6";
        idle(20);
        tag = "R12";
        req(0, 240, 8, 0);
        req(0, 240, 4, 0);
        tag = "R7";
        req(1, 16, 4, 64'h0);
        idle(10);
        tick_div = 3;
        req(1, 16, 4, 64'h1);
        idle(15);

        tag = "R9";
        tick_div = 1;
        req(1, 240, 8, 64'h1234_5678_FFFF_FFF0);
        tag = "R6";
        idle(30);
        tag = "R9";
        req(1, 244, 4, 64'hDEAD_BEEF);
        rd_chk(244, 4, 0, "counter high half");
        req(1, 240, 4, 64'h0000_0100);

        tag = "R10";
        req(1, 32, 8, 64'hFFFF);
        req(1, 256, 8, 64'hFFFF);
        rd_chk(32, 8, 0, "unmapped 0x20");
        rd_chk(8, 8, 0, "unmapped 0x08");
        rd_chk(248, 4, 0, "unmapped 0xF8");

        tag = "R7";
        tick_div = 0;
        req(1, 16, 8, 64'd0);
        idle(5);
        chk(64'(count_enable), 0, "disabled at end");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        vectors++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule